// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Instruction Processor

This block is a compact processor core with one 16-bit accumulator as its only working register. It fetches 16-bit instruction words from a word-addressed single-port memory. The upper four bits of each word choose the operation, and the lower twelve bits carry either a constant or a memory address. The instruction set covers immediate, direct and pointer-indirect loads, direct and pointer-indirect stores, addition from memory, negation, an unconditional jump, three jumps that test the sign of the accumulator, and a stop instruction. The memory array is outside the block. The memory returns read data one clock after the address is presented.

A finite-state machine sequences each instruction. Its states are `ST_FETCH` (present PC), `ST_DECODE` (latch the word, step or load the PC, finish one-step work), `ST_OPRD` (present the address field), `ST_INDRD` (pointer word is on the read bus; present it as an address or write through it), `ST_EXEC` (take a data word or perform a direct write) and `ST_HALT`. The transitions are: FETCH→DECODE always. DECODE→HALT on the stop word. DECODE→OPRD for direct load, pointer load, pointer store and add. DECODE→EXEC for direct store. DECODE→FETCH otherwise. OPRD→INDRD for the two pointer forms, and OPRD→EXEC otherwise. INDRD→EXEC for pointer load and INDRD→FETCH for pointer store. EXEC→FETCH always. HALT→HALT until reset.

Top module: `acc_cpu`

## Requirements
- R1: Reset (active high, asynchronous) clears PC and accumulator to 0 and deasserts halted. While reset is held, the memory address is 0 and the write enable is low.
- R2: An instruction is fetched from the address in PC. When decode completes, PC becomes PC+1 (modulo 2^12), except when a jump is taken.
- R3: Word 0x0000 raises halted. Halted then stays high until reset. While halted, the write enable stays low and PC and accumulator do not change.
- R4: Word 0x0001 replaces the accumulator with its two's-complement negation, modulo 2^16 (so 0x8000 stays 0x8000).
- R5: Opcode 0x1 (bits 15:12) loads bits 11:0, sign-extended from bit 11, into the accumulator.
- R6: Opcode 0x2 loads the accumulator from the word at address bits 11:0. Opcode 0xA adds that word to the accumulator, modulo 2^16. The accumulator changes only in the decode and execute states.
- R7: Opcode 0x3 reads the word at address bits 11:0, takes its low 12 bits as a pointer, and loads the accumulator from the word at the pointer.
- R8: Opcode 0x4 writes the accumulator to address bits 11:0. Opcode 0x5 writes it to the address given by the low 12 bits of the word at address bits 11:0. No other memory location is written.
- R9: Opcode 0x6 sets PC to bits 11:0. Opcodes 0x7, 0x8 and 0x9 do so only when the accumulator, read as signed, is zero, greater than zero, or less than zero, respectively.
- R10: Words 0x0002 to 0x0FFF and opcodes 0xB to 0xF only advance PC and change nothing else.
- R11: Cycle counts per instruction are: 2 for stop, negate, immediate, jumps and no-ops; 3 for direct store; 4 for direct load, add and pointer store; 5 for pointer load. FETCH is always followed by DECODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| mem_addr | output | 12 | Word address to memory |
| mem_wdata | output | 16 | Data to be written |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| mem_we | output | 1 | Write strobe for the current address |
| halted | output | 1 | Stop instruction has executed |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |

## Verification
The embedded properties check, on every clock, the rules that are local in time. These are: the stop state absorbs and holds PC and accumulator while writes stay off; FETCH presents PC and always leads to DECODE; non-jump instructions step PC by one; the accumulator stays frozen outside decode and execute; execute is entered only from decode or a read state. Arithmetic results, sign extension, pointer resolution through the low 12 bits, taken versus untaken branches, exact cycle totals and the absence of stray writes to memory only show up in the bench. The bench runs whole programs (directed ones plus random forward-branching ones) and compares final state, memory contents and elapsed cycles against an instruction-level model.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int OPW = 4;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_OPRD,
        ST_INDRD,
        ST_EXEC,
        ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        ACC_KEEP,
        ACC_NEG,
        ACC_IMM,
        ACC_MEM,
        ACC_ADD
    } acc_sel_e;

    typedef enum logic [1:0] {
        PC_KEEP,
        PC_INC,
        PC_LOAD
    } pc_sel_e;

    typedef enum logic [1:0] {
        AD_PC,
        AD_FIELD,
        AD_PTR
    } addr_sel_e;

    localparam logic [OPW-1:0] OP_SYS = 4'h0;
    localparam logic [OPW-1:0] OP_LDI = 4'h1;
    localparam logic [OPW-1:0] OP_LD  = 4'h2;
    localparam logic [OPW-1:0] OP_LDP = 4'h3;
    localparam logic [OPW-1:0] OP_ST  = 4'h4;
    localparam logic [OPW-1:0] OP_STP = 4'h5;
    localparam logic [OPW-1:0] OP_JMP = 4'h6;
    localparam logic [OPW-1:0] OP_JZ  = 4'h7;
    localparam logic [OPW-1:0] OP_JP  = 4'h8;
    localparam logic [OPW-1:0] OP_JN  = 4'h9;
    localparam logic [OPW-1:0] OP_ADD = 4'hA;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int FW = 12
) (
    input  logic [DW-1:0] acc_q,
    input  logic [DW-1:0] mem_rdata,
    input  acc_sel_e      acc_sel,
    output logic [DW-1:0] acc_next,
    output logic          acc_zero,
    output logic          acc_pos,
    output logic          acc_neg
);

    localparam int EXT = DW - FW;

    logic [DW-1:0] imm_ext;

    assign imm_ext = {{EXT{mem_rdata[FW-1]}}, mem_rdata[FW-1:0]};

    always_comb begin
        unique case (acc_sel)
            ACC_KEEP: acc_next = acc_q;
            ACC_NEG:  acc_next = DW'(0) - acc_q;
            ACC_IMM:  acc_next = imm_ext;
            ACC_MEM:  acc_next = mem_rdata;
            ACC_ADD:  acc_next = acc_q + mem_rdata;
            default:  acc_next = acc_q;
        endcase
    end

    assign acc_zero = (acc_q == '0);
    assign acc_neg  = acc_q[DW-1];
    assign acc_pos  = !acc_zero && !acc_neg;

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  mem_rdata,
    input  logic [OPW-1:0] ir_op,
    input  logic           acc_zero,
    input  logic           acc_pos,
    input  logic           acc_neg,
    output cpu_state_e     state,
    output logic           ir_load,
    output acc_sel_e       acc_sel,
    output pc_sel_e        pc_sel,
    output addr_sel_e      addr_sel,
    output logic           mem_we,
    output logic           halt_set
);

    cpu_state_e     state_q;
    cpu_state_e     state_d;
    logic [OPW-1:0] dec_op;
    logic           dec_stop;
    logic           dec_neg;
    logic           take_jump;

    assign dec_op   = mem_rdata[DW-1 -: OPW];
    assign dec_stop = (mem_rdata == '0);
    assign dec_neg  = (mem_rdata == DW'(1));
    assign state    = state_q;

    always_comb begin
        case (dec_op)
            OP_JMP:  take_jump = 1'b1;
            OP_JZ:   take_jump = acc_zero;
            OP_JP:   take_jump = acc_pos;
            OP_JN:   take_jump = acc_neg;
            default: take_jump = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH: state_d = ST_DECODE;
            ST_DECODE: begin
                case (dec_op)
                    OP_SYS:                        state_d = dec_stop ? ST_HALT : ST_FETCH;
                    OP_LD, OP_LDP, OP_STP, OP_ADD: state_d = ST_OPRD;
                    OP_ST:                         state_d = ST_EXEC;
                    default:                       state_d = ST_FETCH;
                endcase
            end
            ST_OPRD:  state_d = (ir_op == OP_LDP || ir_op == OP_STP) ? ST_INDRD : ST_EXEC;
            ST_INDRD: state_d = (ir_op == OP_LDP) ? ST_EXEC : ST_FETCH;
            ST_EXEC:  state_d = ST_FETCH;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_FETCH;
        endcase
    end

    // outputs
    always_comb begin
        ir_load  = 1'b0;
        acc_sel  = ACC_KEEP;
        pc_sel   = PC_KEEP;
        addr_sel = AD_PC;
        mem_we   = 1'b0;
        halt_set = 1'b0;
        unique case (state_q)
            ST_FETCH: addr_sel = AD_PC;
            ST_DECODE: begin
                ir_load = 1'b1;
                pc_sel  = take_jump ? PC_LOAD : PC_INC;
                if (dec_op == OP_SYS) begin
                    halt_set = dec_stop;
                    acc_sel  = dec_neg ? ACC_NEG : ACC_KEEP;
                end else if (dec_op == OP_LDI) begin
                    acc_sel = ACC_IMM;
                end
            end
            ST_OPRD: addr_sel = AD_FIELD;
            ST_INDRD: begin
                addr_sel = AD_PTR;
                mem_we   = (ir_op == OP_STP);
            end
            ST_EXEC: begin
                case (ir_op)
                    OP_LD, OP_LDP: acc_sel = ACC_MEM;
                    OP_ADD:        acc_sel = ACC_ADD;
                    OP_ST: begin
                        addr_sel = AD_FIELD;
                        mem_we   = 1'b1;
                    end
                    default: acc_sel = ACC_KEEP;
                endcase
            end
            ST_HALT: addr_sel = AD_PC;
            default: addr_sel = AD_PC;
        endcase
    end

    p_fetch_to_decode_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

    p_halt_absorbs_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));

    p_exec_entry_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC) |-> ($past(state_q) == ST_DECODE || $past(state_q) == ST_OPRD
                                  || $past(state_q) == ST_INDRD));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we,
    output logic          halted,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] acc
);

    localparam int FW = DW - OPW;

    logic [AW-1:0] pc_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] ir_q;
    logic          halted_q;
    logic [DW-1:0] acc_next;
    logic          acc_zero;
    logic          acc_pos;
    logic          acc_neg;
    cpu_state_e    state;
    logic          ir_load;
    acc_sel_e      acc_sel;
    pc_sel_e       pc_sel;
    addr_sel_e     addr_sel;
    logic          halt_set;

    acc_cpu_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .ir_op     (ir_q[DW-1 -: OPW]),
        .acc_zero  (acc_zero),
        .acc_pos   (acc_pos),
        .acc_neg   (acc_neg),
        .state     (state),
        .ir_load   (ir_load),
        .acc_sel   (acc_sel),
        .pc_sel    (pc_sel),
        .addr_sel  (addr_sel),
        .mem_we    (mem_we),
        .halt_set  (halt_set)
    );

    acc_cpu_alu #(.DW(DW), .FW(FW)) u_alu (
        .acc_q     (acc_q),
        .mem_rdata (mem_rdata),
        .acc_sel   (acc_sel),
        .acc_next  (acc_next),
        .acc_zero  (acc_zero),
        .acc_pos   (acc_pos),
        .acc_neg   (acc_neg)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            pc_q     <= '0;
            acc_q    <= '0;
            ir_q     <= '0;
            halted_q <= 1'b0;
        end else begin
            if (ir_load) begin
                ir_q <= mem_rdata;
            end
            unique case (pc_sel)
                PC_INC:  pc_q <= pc_q + AW'(1);
                PC_LOAD: pc_q <= mem_rdata[AW-1:0];
                default: pc_q <= pc_q;
            endcase
            acc_q <= acc_next;
            if (halt_set) begin
                halted_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (addr_sel)
            AD_FIELD: mem_addr = ir_q[AW-1:0];
            AD_PTR:   mem_addr = mem_rdata[AW-1:0];
            default:  mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = acc_q;
    assign halted    = halted_q;
    assign pc        = pc_q;
    assign acc       = acc_q;

    p_halt_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    p_halt_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        halted |=> ($stable(pc_q) && $stable(acc_q)));

    p_fetch_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |-> (mem_addr == pc_q));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE && mem_rdata != '0
         && (mem_rdata[DW-1 -: OPW] < OP_JMP || mem_rdata[DW-1 -: OPW] > OP_JN))
        |=> ((pc_q - $past(pc_q)) == AW'(1)));

    p_acc_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_DECODE && state != ST_EXEC) |=> $stable(acc_q));

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

    localparam int DW   = 16;
    localparam int AW   = 12;
    localparam int MEMW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_we;
    logic          halted;
    logic [AW-1:0] pc;
    logic [DW-1:0] acc;

    logic [DW-1:0] ram     [0:MEMW-1];
    logic [DW-1:0] ref_mem [0:MEMW-1];

    int n_vec     = 0;
    int n_bad     = 0;
    int cyc_total = 0;

    always #2 clk = ~clk;

    acc_cpu #(.DW(DW), .AW(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .halted    (halted),
        .pc        (pc),
        .acc       (acc)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    initial begin
        forever begin
            @(posedge clk);
            cyc_total++;
            if (cyc_total >= 150000) begin
                n_vec++;
                n_bad++;
                $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc_total);
                $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [DW-1:0] w);
        ram[a]     = w;
        ref_mem[a] = w;
    endtask

    // R1: reset state, applied before each program is loaded
    task automatic begin_prog();
        rst = 1'b1;
        @(negedge clk);
        check(pc == '0,       "R1", "pc in reset",     32'(pc),       32'h0);
        check(acc == '0,      "R1", "acc in reset",    32'(acc),      32'h0);
        check(!halted,        "R1", "halted in reset", 32'(halted),   32'h0);
        check(mem_addr == '0 && !mem_we, "R1", "bus in reset",
              {15'h0, mem_we, 4'h0, mem_addr}, 32'h0);
        for (int a = 0; a < MEMW; a++) begin
            ram[a]     = '0;
            ref_mem[a] = '0;
        end
    endtask

    // instruction-level model
    task automatic model(output logic [DW-1:0] e_acc, output logic [AW-1:0] e_pc,
                         output int e_cyc);
        logic [DW-1:0] ins;
        logic [AW-1:0] f;
        logic [AW-1:0] p;
        bit done;
        e_acc = '0;
        e_pc  = '0;
        e_cyc = 0;
        done  = 1'b0;
        for (int step = 0; step < 1000 && !done; step++) begin
            ins  = ref_mem[e_pc];
            e_pc = e_pc + AW'(1);
            f    = ins[AW-1:0];
            case (ins[15:12])
                4'h0: begin
                    if (ins == 16'h0000) done = 1'b1;
                    else if (ins == 16'h0001) e_acc = 16'h0 - e_acc;
                    e_cyc += 2;
                end
                4'h1: begin e_acc = {{4{f[11]}}, f}; e_cyc += 2; end
                4'h2: begin e_acc = ref_mem[f]; e_cyc += 4; end
                4'h3: begin p = ref_mem[f][AW-1:0]; e_acc = ref_mem[p]; e_cyc += 5; end
                4'h4: begin ref_mem[f] = e_acc; e_cyc += 3; end
                4'h5: begin p = ref_mem[f][AW-1:0]; ref_mem[p] = e_acc; e_cyc += 4; end
                4'h6: begin e_pc = f; e_cyc += 2; end
                4'h7: begin if (e_acc == 0) e_pc = f; e_cyc += 2; end
                4'h8: begin if (!e_acc[15] && e_acc != 0) e_pc = f; e_cyc += 2; end
                4'h9: begin if (e_acc[15]) e_pc = f; e_cyc += 2; end
                4'hA: begin e_acc = e_acc + ref_mem[f]; e_cyc += 4; end
                default: e_cyc += 2;
            endcase
        end
    endtask

    task automatic run_check(input string name);
        logic [DW-1:0] e_acc;
        logic [AW-1:0] e_pc;
        int            e_cyc;
        int            cycles;
        int            bad_at;
        logic [AW-1:0] pc_h;
        logic [DW-1:0] acc_h;
        bit            hold_bad;
        model(e_acc, e_pc, e_cyc);
        rst    = 1'b0;
        cycles = 0;
        while (!halted && cycles < 4000) begin
            @(negedge clk);
            cycles++;
        end
        check(halted == 1'b1, "R3", {name, " halt reached"}, 32'(halted), 32'h1);
        check(cycles == e_cyc, "R11", {name, " cycles to halt"}, 32'(cycles), 32'(e_cyc));
        check(acc == e_acc, "R6", {name, " final acc"}, 32'(acc), 32'(e_acc));
        check(pc == e_pc, "R2", {name, " final pc"}, 32'(pc), 32'(e_pc));
        bad_at = -1;
        for (int a = 0; a < MEMW; a++) begin
            if (bad_at < 0 && ram[a] !== ref_mem[a]) bad_at = a;
        end
        check(bad_at < 0, "R8", {name, " memory image"},
              (bad_at < 0) ? 32'h0 : 32'(ram[bad_at]),
              (bad_at < 0) ? 32'h0 : 32'(ref_mem[bad_at]));
        pc_h     = pc;
        acc_h    = acc;
        hold_bad = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (mem_we || !halted || pc != pc_h || acc != acc_h) hold_bad = 1'b1;
        end
        check(!hold_bad, "R3", {name, " halted hold"}, 32'(hold_bad), 32'h0);
    endtask

    task automatic gen_random();
        int n;
        int k;
        logic [DW-1:0] w;
        logic [AW-1:0] tgt;
        for (int a = 12'h800; a < 12'h900; a++) put(a, 16'($urandom));
        for (int a = 12'h900; a < 12'h910; a++) put(a, {4'($urandom), 4'h8, 8'($urandom)});
        n = 16 + $urandom_range(0, 15);
        for (int i = 0; i < n; i++) begin
            k   = $urandom_range(0, 15);
            tgt = 12'(i + 1 + $urandom_range(0, n - i - 1));
            case (k)
                0:       w = 16'h0001;
                1, 2:    w = {4'h1, 12'($urandom)};
                3:       w = {4'h2, 4'h8, 8'($urandom)};
                4:       w = {4'h3, 8'h90, 4'($urandom)};
                5, 6:    w = {4'h4, 4'h8, 8'($urandom)};
                7:       w = {4'h5, 8'h90, 4'($urandom)};
                8:       w = {4'h6, tgt};
                9:       w = {4'h7, tgt};
                10:      w = {4'h8, tgt};
                11:      w = {4'h9, tgt};
                12, 13:  w = {4'hA, 4'h8, 8'($urandom)};
                14:      w = 16'h0002 + 16'($urandom_range(0, 12'hFFD));
                default: w = {4'($urandom_range(11, 15)), 12'($urandom)};
            endcase
            put(i, w);
        end
        put(n, 16'h0000);
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd5179);
        repeat (3) @(negedge clk);

        // R5 sign extension, R4 negate, R8 direct store
        begin_prog();
        put(0, 16'h1800); put(1, 16'h4810); put(2, 16'h0001); put(3, 16'h0000);
        run_check("imm/neg");
        check(acc == 16'h0800, "R4", "negate of 0xF800", 32'(acc), 32'h0800);
        check(ram[12'h810] == 16'hF800, "R5", "stored sign-extended imm",
              32'(ram[12'h810]), 32'hF800);

        // R4 negation wraps for the most negative value
        begin_prog();
        put(12'h820, 16'h8000);
        put(0, 16'h2820); put(1, 16'h0001); put(2, 16'h0000);
        run_check("neg wrap");
        check(acc == 16'h8000, "R4", "negate 0x8000", 32'(acc), 32'h8000);

        // R9 branches with zero, then negative accumulator
        begin_prog();
        put(0, 16'h1000); put(1, 16'h8005); put(2, 16'h9005); put(3, 16'h7006);
        put(4, 16'h1123); put(5, 16'h1456); put(6, 16'h1FFF); put(7, 16'h700B);
        put(8, 16'h800B); put(9, 16'h900C); put(10, 16'h1777); put(11, 16'h1888);
        put(12, 16'h0000);
        run_check("branches");
        check(acc == 16'hFFFF, "R9", "branch path acc", 32'(acc), 32'hFFFF);
        check(pc == 12'd13, "R9", "branch path pc", 32'(pc), 32'd13);

        // R10 no-operation encodings
        begin_prog();
        put(0, 16'h0002); put(1, 16'h0FFF); put(2, 16'hB123); put(3, 16'hFFFF);
        put(4, 16'h0000);
        run_check("nops");
        check(acc == 16'h0000 && pc == 12'd5, "R10", "nops leave acc, step pc",
              {acc, 4'h0, pc}, {16'h0, 4'h0, 12'd5});

        // R7 pointer load, R8 pointer store, R6 add
        begin_prog();
        put(12'h905, 16'hF830); put(12'h830, 16'h1234);
        put(0, 16'h3905); put(1, 16'h1055); put(2, 16'h5905); put(3, 16'hA830);
        put(4, 16'h0000);
        run_check("indirect");
        check(ram[12'h830] == 16'h0055, "R8", "pointer store target",
              32'(ram[12'h830]), 32'h0055);
        check(acc == 16'h00AA, "R7", "pointer load then add", 32'(acc), 32'h00AA);

        // random forward-branching programs
        for (int t = 0; t < 40; t++) begin
            begin_prog();
            gen_random();
            run_check("random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule